// File: doc/BRIEF.md
# Two-Cycle Flash Command Interface

This block sits between a host bus and the embedded sequencer of a byte-wide flash model. It watches the active-low chip-select, output-select and write strobes. It turns qualified bus writes into command-state changes, and it issues single-cycle start requests for a chip erase or a byte program, with the latched target address and data. It also issues an abort request when a running operation has to be stopped. The strobes and the two supply-condition inputs are asynchronous, so they are brought into a fast system clock through a synchronizer chain. Edges are found in that clock domain.

Erase and program each take two bus writes. A write is only accepted while the high-voltage-present input is high and the low-supply lockout input is low. The block also chooses what a read returns:
- the array data supplied from outside,
- one of two fixed identifier bytes, or
- a status byte while an operation is running.

The status byte has a completion bit and a bit that toggles on each read. The sequencer reports the end of an operation with a one-cycle done pulse, and the block then goes back to array reads.

Top module: `flash_cmd_if`

## Requirements
- R1: After synchronous reset the block is in array-read mode: `prog_start`, `erase_start` and `seq_abort` are low, and a read returns `arr_rdata`.
- R2: A bus write is accepted only while `ce_n` and `we_n` are both low and `oe_n` is high. A write pulse with `oe_n` low, or with `we_n` low while `ce_n` is high, has no effect on the mode.
- R3: While `hv_ok` is low, every write is ignored and the block is held in array-read mode. If `hv_ok` falls while an operation is running, one `seq_abort` pulse is issued.
- R4: Data 00h or FFh written in array-read, identifier or erase-setup mode selects array-read mode and starts nothing.
- R5: Data 80h or 90h selects identifier mode. In that mode a read returns 01h when `addr[0]`=0 and 2Fh when `addr[0]`=1; the other address bits are ignored. Both bytes have odd parity, with bit 7 as the parity bit. An unrecognized write code leaves the block in identifier mode.
- R6: Writing 30h twice gives exactly one `erase_start` pulse, after the end of the second write. If the second write is any code other than 30h, the block returns to array-read mode and no erase starts.
- R7: After 10h or 50h, the next write gives exactly one `prog_start` pulse. `op_addr` and `op_data` carry that write's address and data. `prog_start` and `erase_start` are never high together.
- R8: After program setup, a write of FFh starts nothing and leaves the block still waiting for program data. A following 00h or FFh returns it to array-read mode. Any other value is taken as program data and starts a program.
- R9: While an operation runs, reads return status. Bit 7 is 0 during erase and the complement of `op_data[7]` during program. Bit 6 alternates on successive read cycles. Bits 5..0 are 0. Writes are ignored. A `seq_done` pulse returns the block to array-read mode.
- R10: While `lockout` is high, the block is forced to array-read mode, a running operation gets one `seq_abort` pulse, and all writes are ignored. Writes are accepted again once `lockout` is low.
- R11: The address is captured when a qualified write begins (the later falling strobe). The data is captured when it ends (the earlier rising strobe). An address change late in the pulse does not affect the captured address, and a data change before the pulse ends does affect the captured data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the strobes |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output select, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | AW | Host address bus |
| din | input | 8 | Host write data |
| hv_ok | input | 1 | High programming voltage present, asynchronous |
| lockout | input | 1 | Low-supply lockout, asynchronous |
| seq_done | input | 1 | One-cycle pulse from the sequencer when an operation ends |
| arr_rdata | input | 8 | Array byte at the current address |
| rdata | output | 8 | Registered read data (array, identifier or status) |
| prog_start | output | 1 | One-cycle request to program a byte |
| erase_start | output | 1 | One-cycle request to erase the chip |
| seq_abort | output | 1 | One-cycle request to stop the running operation |
| op_addr | output | AW | Latched program address |
| op_data | output | 8 | Latched program data |

## Verification
The bench builds the block with its defaults:
- a 15-bit address bus,
- a two-stage synchronizer, and
- the identifier bytes 01h and 2Fh.

With these values, a write pulse of about ten clocks is long enough to move the address and the data at chosen points inside the pulse. That makes the rule of early address capture and late data capture observable from outside. Bit 0 of the short address selects between the two identifier bytes, and a higher address bit is set to confirm that it is ignored. An array model that is a simple function of the low address byte shows whether a read came from the array, the identifier bytes or the status byte.

// File: rtl/fci_pkg.sv
package fci_pkg;

  typedef enum logic [2:0] {
    ST_READ,
    ST_IDENT,
    ST_ERS_SETUP,
    ST_PGM_SETUP,
    ST_PGM_RSTPEND,
    ST_ERASING,
    ST_PROGRAMMING
  } fci_state_e;

  localparam logic [7:0] CODE_RD_A  = 8'h00;
  localparam logic [7:0] CODE_RD_B  = 8'hFF;
  localparam logic [7:0] CODE_ID_A  = 8'h80;
  localparam logic [7:0] CODE_ID_B  = 8'h90;
  localparam logic [7:0] CODE_ERASE = 8'h30;
  localparam logic [7:0] CODE_PGM_A = 8'h10;
  localparam logic [7:0] CODE_PGM_B = 8'h50;

  // Mode picked by a first-cycle command; unknown codes keep the current mode.
  function automatic fci_state_e fci_decode(input logic [7:0] code, input fci_state_e cur);
    fci_state_e nxt;
    case (code)
      CODE_RD_A, CODE_RD_B:   nxt = ST_READ;
      CODE_ID_A, CODE_ID_B:   nxt = ST_IDENT;
      CODE_ERASE:             nxt = ST_ERS_SETUP;
      CODE_PGM_A, CODE_PGM_B: nxt = ST_PGM_SETUP;
      default:                nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/fci_sync.sv
module fci_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fci_wr_detect.sv
module fci_wr_detect #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_s,
  input  logic          oe_s,
  input  logic          we_s,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic          wr_evt,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          rd_rise
);
  logic wr_lvl, wr_d, rd_lvl, rd_d;

  assign wr_lvl = !ce_s && !we_s && oe_s;
  assign rd_lvl = !ce_s && !oe_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_d    <= 1'b0;
      rd_d    <= 1'b0;
      wr_evt  <= 1'b0;
      rd_rise <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_d    <= wr_lvl;
      rd_d    <= rd_lvl;
      rd_rise <= rd_lvl && !rd_d;
      wr_evt  <= wr_d && !wr_lvl;
      if (wr_lvl && !wr_d) wr_addr <= addr;   // later of the two falling strobes
      if (wr_d && !wr_lvl) wr_data <= din;    // earlier of the two rising strobes
    end
  end
endmodule

// File: rtl/fci_cmd_fsm.sv
module fci_cmd_fsm
  import fci_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_evt,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_rise,
  input  logic          hv_s,
  input  logic          lock_s,
  input  logic          seq_done,
  output fci_state_e    state,
  output logic          prog_start,
  output logic          erase_start,
  output logic          seq_abort,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          tog
);
  logic busy;
  assign busy = (state == ST_ERASING) || (state == ST_PROGRAMMING);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_READ;
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
      seq_abort   <= 1'b0;
      op_addr     <= '0;
      op_data     <= '0;
      tog         <= 1'b0;
    end else begin
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
      seq_abort   <= 1'b0;
      if (lock_s || !hv_s) begin
        state     <= ST_READ;
        seq_abort <= busy;
      end else if (busy) begin
        if (seq_done) state <= ST_READ;
        if (rd_rise)  tog   <= !tog;
      end else if (wr_evt) begin
        case (state)
          ST_ERS_SETUP: begin
            if (wr_data == CODE_ERASE) begin
              state       <= ST_ERASING;
              erase_start <= 1'b1;
              tog         <= 1'b0;
            end else begin
              state <= ST_READ;
            end
          end
          ST_PGM_SETUP, ST_PGM_RSTPEND: begin
            if (state == ST_PGM_SETUP && wr_data == CODE_RD_B) begin
              state <= ST_PGM_RSTPEND;
            end else if (state == ST_PGM_RSTPEND &&
                         (wr_data == CODE_RD_A || wr_data == CODE_RD_B)) begin
              state <= ST_READ;
            end else begin
              state      <= ST_PROGRAMMING;
              prog_start <= 1'b1;
              op_addr    <= wr_addr;
              op_data    <= wr_data;
              tog        <= 1'b0;
            end
          end
          default: state <= fci_decode(wr_data, state);
        endcase
      end
    end
  end
endmodule

// File: rtl/fci_rd_mux.sv
module fci_rd_mux
  import fci_pkg::*;
#(
  parameter int AW = 15,
  parameter logic [7:0] MFR_CODE = 8'h01,
  parameter logic [7:0] DEV_CODE = 8'h2F
) (
  input  logic          clk,
  input  logic          rst,
  input  fci_state_e    state,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    arr_rdata,
  input  logic [7:0]    op_data,
  input  logic          tog,
  output logic [7:0]    rdata
);
  logic [7:0] nxt;

  always_comb begin
    case (state)
      ST_IDENT:       nxt = addr[0] ? DEV_CODE : MFR_CODE;
      ST_ERASING:     nxt = {1'b0, tog, 6'b0};
      ST_PROGRAMMING: nxt = {!op_data[7], tog, 6'b0};
      default:        nxt = arr_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= nxt;
  end
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fci_pkg::*;
#(
  parameter int AW = 15,
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] MFR_CODE = 8'h01,
  parameter logic [7:0] DEV_CODE = 8'h2F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic          hv_ok,
  input  logic          lockout,
  input  logic          seq_done,
  input  logic [7:0]    arr_rdata,
  output logic [7:0]    rdata,
  output logic          prog_start,
  output logic          erase_start,
  output logic          seq_abort,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data
);
  localparam int SW = 5;
  localparam logic [SW-1:0] SYNC_RST = 5'b00111;  // strobes idle high, supplies off

  logic [SW-1:0] async_in, sync_out;
  logic ce_s, oe_s, we_s, hv_s, lock_s;
  logic wr_evt, rd_rise, tog;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  fci_state_e state;

  assign async_in = {lockout, hv_ok, we_n, oe_n, ce_n};
  assign {lock_s, hv_s, we_s, oe_s, ce_s} = sync_out;

  fci_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(async_in), .q(sync_out)
  );

  fci_wr_detect #(.AW(AW)) u_wr (
    .clk(clk), .rst(rst), .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s),
    .addr(addr), .din(din), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_rise(rd_rise)
  );

  fci_cmd_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst(rst), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_rise(rd_rise), .hv_s(hv_s), .lock_s(lock_s),
    .seq_done(seq_done), .state(state), .prog_start(prog_start),
    .erase_start(erase_start), .seq_abort(seq_abort), .op_addr(op_addr),
    .op_data(op_data), .tog(tog)
  );

  fci_rd_mux #(.AW(AW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rd (
    .clk(clk), .rst(rst), .state(state), .addr(addr), .arr_rdata(arr_rdata),
    .op_data(op_data), .tog(tog), .rdata(rdata)
  );
endmodule

// File: rtl/fci_chk.sv
module fci_chk (
  input logic clk,
  input logic rst,
  input logic lock_s,
  input logic hv_s,
  input logic prog_start,
  input logic erase_start,
  input logic seq_abort
);
  a_r6_single_erase: assert property (@(posedge clk) disable iff (rst)
    erase_start |=> !erase_start);

  a_r7_single_prog: assert property (@(posedge clk) disable iff (rst)
    prog_start |=> !prog_start);

  a_r7_start_excl: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> !erase_start);

  a_r10_lock_quiet: assert property (@(posedge clk) disable iff (rst)
    lock_s |=> (!prog_start && !erase_start));

  a_r3_hv_gate: assert property (@(posedge clk) disable iff (rst)
    !hv_s |=> (!prog_start && !erase_start));

  a_r10_abort_cause: assert property (@(posedge clk) disable iff (rst)
    seq_abort |-> ($past(lock_s) || !$past(hv_s)));
endmodule

bind flash_cmd_if fci_chk u_chk (
  .clk(clk), .rst(rst), .lock_s(lock_s), .hv_s(hv_s),
  .prog_start(prog_start), .erase_start(erase_start), .seq_abort(seq_abort)
);

// File: tb/tb_flash_cmd_if.sv
`timescale 1ns/1ps
module tb_flash_cmd_if;
  localparam int AW = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic hv_ok = 1'b1, lockout = 1'b0, seq_done = 1'b0;
  logic [7:0] arr_rdata, rdata;
  logic prog_start, erase_start, seq_abort;
  logic [AW-1:0] op_addr;
  logic [7:0] op_data;

  int n_chk = 0, n_err = 0;
  int n_prog = 0, n_ers = 0, n_abt = 0;
  logic [AW-1:0] cap_addr = '0;
  logic [7:0] cap_data = '0;

  always #4 clk = !clk;

  assign arr_rdata = addr[7:0] ^ 8'h5A;

  flash_cmd_if dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .din(din), .hv_ok(hv_ok), .lockout(lockout), .seq_done(seq_done),
    .arr_rdata(arr_rdata), .rdata(rdata), .prog_start(prog_start),
    .erase_start(erase_start), .seq_abort(seq_abort), .op_addr(op_addr),
    .op_data(op_data)
  );

  always @(posedge clk) begin
    if (prog_start) begin
      n_prog   <= n_prog + 1;
      cap_addr <= op_addr;
      cap_data <= op_data;
    end
    if (erase_start) n_ers <= n_ers + 1;
    if (seq_abort)   n_abt <= n_abt + 1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Write with address switching to a2 and data to d2 partway through the pulse.
  task automatic wr_split(input logic [AW-1:0] a1, input logic [7:0] d1,
                          input logic [AW-1:0] a2, input logic [7:0] d2);
    @(negedge clk);
    addr = a1; din = d1; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    idle(5);
    addr = a2; din = d2;
    idle(5);
    we_n = 1'b1;
    idle(6);
    ce_n = 1'b1;
    idle(4);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_split(a, d, a, d);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    idle(8);
    d = rdata;
    oe_n = 1'b1; ce_n = 1'b1;
    idle(4);
  endtask

  task automatic done_pulse();
    @(negedge clk); seq_done = 1'b1;
    @(negedge clk); seq_done = 1'b0;
    idle(4);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    idle(2);
    chk("R1", "prog_start after reset", int'(prog_start), 0);
    chk("R1", "erase_start after reset", int'(erase_start), 0);
    chk("R1", "seq_abort after reset", int'(seq_abort), 0);
    rd(15'h0012, d);
    chk("R1", "array read after reset", int'(d), 8'h48);
  endtask

  task automatic t_ident();
    logic [7:0] d;
    wr(15'h0000, 8'h90);
    rd(15'h0000, d);  chk("R5", "mfr code", int'(d), 8'h01);
    rd(15'h0001, d);  chk("R5", "dev code", int'(d), 8'h2F);
    chk("R5", "dev code odd parity", $countones(d) % 2, 1);
    rd(15'h4002, d);  chk("R5", "upper addr bits ignored", int'(d), 8'h01);
    wr(15'h0000, 8'h55);
    rd(15'h0001, d);  chk("R5", "unknown code keeps ident", int'(d), 8'h2F);
    wr(15'h0000, 8'h00);
    rd(15'h0001, d);  chk("R4", "00h leaves ident", int'(d), 8'h5B);
    wr(15'h0000, 8'h80);
    rd(15'h0000, d);  chk("R5", "80h enters ident", int'(d), 8'h01);
    wr(15'h0000, 8'hFF);
    rd(15'h0000, d);  chk("R4", "FFh leaves ident", int'(d), 8'h5A);
  endtask

  task automatic t_erase();
    logic [7:0] d1, d2;
    int e0 = n_ers;
    wr(15'h0000, 8'h30);
    chk("R6", "no erase after setup only", n_ers - e0, 0);
    wr(15'h0000, 8'h30);
    chk("R6", "one erase pulse", n_ers - e0, 1);
    rd(15'h0003, d1);
    rd(15'h0003, d2);
    chk("R9", "erase status bit7", int'(d1[7]), 0);
    chk("R9", "status low bits zero", int'(d1[5:0]), 0);
    chk("R9", "bit6 alternates", int'(d1[6] ^ d2[6]), 1);
    wr(15'h0000, 8'h90);
    rd(15'h0000, d1);
    chk("R9", "write ignored while busy", int'(d1[7:6] == 2'b00 || d1[7:6] == 2'b01), 1);
    done_pulse();
    rd(15'h0000, d1);
    chk("R9", "array after done", int'(d1), 8'h5A);
    chk("R6", "still one erase pulse", n_ers - e0, 1);
  endtask

  task automatic t_erase_bad();
    logic [7:0] d;
    int e0 = n_ers;
    wr(15'h0000, 8'h30);
    wr(15'h0000, 8'h40);
    rd(15'h0001, d);
    chk("R6", "bad second write gives array", int'(d), 8'h5B);
    chk("R6", "bad second write no erase", n_ers - e0, 0);
    wr(15'h0000, 8'h30);
    wr(15'h0000, 8'hFF);
    rd(15'h0001, d);
    chk("R4", "FFh after erase setup reads array", int'(d), 8'h5B);
    chk("R4", "FFh after erase setup no erase", n_ers - e0, 0);
  endtask

  task automatic t_prog();
    logic [7:0] d;
    int p0 = n_prog;
    wr(15'h0000, 8'h50);
    wr(15'h1234, 8'h3C);
    chk("R7", "one program pulse", n_prog - p0, 1);
    chk("R7", "program address", int'(cap_addr), 15'h1234);
    chk("R7", "program data", int'(cap_data), 8'h3C);
    rd(15'h1234, d);
    chk("R9", "program status bit7 complement", int'(d[7]), 1);
    done_pulse();
    wr(15'h0000, 8'h10);
    wr(15'h0077, 8'h80);
    chk("R7", "10h setup programs", n_prog - p0, 2);
    rd(15'h0077, d);
    chk("R9", "program status bit7 for data 80h", int'(d[7]), 0);
    done_pulse();
    rd(15'h0077, d);
    chk("R9", "array after program done", int'(d), 8'h2D);
  endtask

  task automatic t_dbl_reset();
    logic [7:0] d;
    int p0 = n_prog;
    wr(15'h0000, 8'h10);
    wr(15'h0000, 8'hFF);
    chk("R8", "first FFh starts nothing", n_prog - p0, 0);
    wr(15'h0007, 8'hA5);
    chk("R8", "data after FFh programs", n_prog - p0, 1);
    chk("R8", "data after FFh value", int'(cap_data), 8'hA5);
    done_pulse();
    wr(15'h0000, 8'h50);
    wr(15'h0000, 8'hFF);
    wr(15'h0000, 8'hFF);
    chk("R8", "second FFh starts nothing", n_prog - p0, 1);
    rd(15'h0004, d);
    chk("R8", "second FFh reads array", int'(d), 8'h5E);
    wr(15'h0000, 8'h66);
    chk("R8", "back in read mode", n_prog - p0, 1);
  endtask

  task automatic t_qualify();
    logic [7:0] d;
    @(negedge clk);
    din = 8'h90; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    idle(10); we_n = 1'b1; idle(4); ce_n = 1'b1; oe_n = 1'b1; idle(4);
    rd(15'h0000, d);
    chk("R2", "write with oe low ignored", int'(d), 8'h5A);
    @(negedge clk);
    din = 8'h90; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b0;
    idle(10); we_n = 1'b1; idle(4);
    rd(15'h0000, d);
    chk("R2", "write with ce high ignored", int'(d), 8'h5A);
  endtask

  task automatic t_hv();
    logic [7:0] d;
    int a0 = n_abt, e0 = n_ers;
    hv_ok = 1'b0; idle(4);
    wr(15'h0000, 8'h90);
    rd(15'h0000, d);
    chk("R3", "write ignored without hv", int'(d), 8'h5A);
    hv_ok = 1'b1; idle(4);
    wr(15'h0000, 8'h30);
    wr(15'h0000, 8'h30);
    chk("R3", "erase started with hv", n_ers - e0, 1);
    hv_ok = 1'b0; idle(8);
    chk("R3", "hv drop aborts once", n_abt - a0, 1);
    hv_ok = 1'b1; idle(4);
    rd(15'h0001, d);
    chk("R3", "array after hv abort", int'(d), 8'h5B);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    int a0 = n_abt, p0 = n_prog;
    wr(15'h0000, 8'h50);
    wr(15'h0010, 8'h11);
    chk("R10", "program started", n_prog - p0, 1);
    lockout = 1'b1; idle(10);
    chk("R10", "lockout aborts once", n_abt - a0, 1);
    wr(15'h0000, 8'h90);
    rd(15'h0000, d);
    chk("R10", "writes ignored in lockout", int'(d), 8'h5A);
    lockout = 1'b0; idle(4);
    rd(15'h0001, d);
    chk("R10", "array after lockout", int'(d), 8'h5B);
    wr(15'h0000, 8'h90);
    rd(15'h0001, d);
    chk("R10", "writes accepted after lockout", int'(d), 8'h2F);
    wr(15'h0000, 8'hFF);
  endtask

  task automatic t_edges();
    int p0 = n_prog;
    wr(15'h0000, 8'h50);
    wr_split(15'h0ABC, 8'h12, 15'h0555, 8'h9E);
    chk("R11", "program pulse", n_prog - p0, 1);
    chk("R11", "address from start of pulse", int'(cap_addr), 15'h0ABC);
    chk("R11", "data from end of pulse", int'(cap_data), 8'h9E);
    done_pulse();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    t_reset();
    t_ident();
    t_erase();
    t_erase_bad();
    t_prog();
    t_dbl_reset();
    t_qualify();
    t_hv();
    t_lock();
    t_edges();
    idle(4);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule